// File: doc/BRIEF.md
# Masked Response Compare and Branch

This block closes one hardware test step. After a test has run and its results are in storage, a start pulse hands it the byte address of a ten-word test descriptor. The block first copies the descriptor's two pointer words, the actual-response pointer and the mask pointer, into two fixed storage locations. It then reads them back, fetches the actual response and the mask through them, fetches the expected response, and compares actual against expected in every bit the mask enables.

From the comparison, a termination flag in the descriptor and an internal repeat counter, the block decides on one of three outcomes: pass, fail, or repeat the same test. It then fetches the matching next-test start address from the descriptor. A single-cycle result strobe carries the outcome, the chosen address and the test and segment numbers taken from the descriptor's last word. Storage is reached through a single-port word memory interface with a read latency of one cycle. A test is repeated up to 15 times before a persistent mismatch is declared a failure.

Descriptor layout, as byte offsets from the start address: +0 actual-response pointer, +4 mask pointer, +8 mask, +12 expected response, +16 this-test start (repeat), +20 next-test start, +24 flags, +28 restart address, +32 forced-pass next address, +36 test/segment word.

Top module: `resp_check_branch`

## Requirements
- R1: After a start is accepted, the descriptor word at +0 is written to byte address 0x080 and the word at +4 to byte address 0x084; the block writes to no other address.
- R2: The actual response is read from the address held at 0x080 after that write, the mask from the address held at 0x084, and the expected response from descriptor offset +12.
- R3: The compare matches when actual and expected agree in every bit where the mask is 1; a bit where the mask is 0 never causes a mismatch.
- R4: On a match the result has pass=1 and repeat=0, the next address is the word at +20 when the termination flag is clear and the word at +32 when it is set, and the repeat counter returns to 0.
- R5: The termination flag is bit 7 (bit 0 being the least significant) of the word at +24; no other bit of that word affects the result.
- R6: On a mismatch with fewer than 15 repeats counted, the result has repeat=1 and pass=0, the next address is the word at +16, and the counter increases by one.
- R7: On a mismatch with 15 repeats counted, the result has pass=0 and repeat=0 (fail), the next address is the word at +20 when the flag is clear and the word at +28 when it is set, and the counter returns to 0.
- R8: The result reports the test number as bits 15:8 and the segment number as bits 7:0 of the word at +36.
- R9: The result strobe is high for exactly one cycle, 13 clock edges after the edge at which the start was accepted.
- R10: A start seen while a check is in progress is ignored: it produces no extra strobe and leaves the result unchanged.
- R11: During reset the strobe and memory enable are low and the result fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; accepted only when idle |
| tbl_base | input | AW (12) | Byte address of the test descriptor |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (12) | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Result is pass |
| res_repeat | output | 1 | Result is repeat; fail when both pass and repeat are 0 |
| res_next | output | 32 | Chosen next-test start address |
| res_test | output | 8 | Test number |
| res_seg | output | 8 | Segment number |

## Verification
Identical words under a full mask give the plain pass path, while words that differ only where the mask is 0, and a zero mask over unrelated words, separate a masked compare from a raw one. Flag words with bits 6 and 8 set but bit 7 clear, against ones with bit 7 set, tell the correct flag position apart from its neighbours and steer the four address choices. Runs of 15 mismatches followed by a 16th, and a run of 14 broken by a match, show where the counter saturates and that both a pass and a fail clear it. Pointers and descriptor bases change between tests so that a stale pointer or a missing save write gives a wrong actual response.

// File: rtl/rcb_pkg.sv
`timescale 1ns/1ps
package rcb_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // descriptor byte offsets
  localparam int unsigned OFF_PACT = 0;
  localparam int unsigned OFF_PMSK = 4;
  localparam int unsigned OFF_EXP  = 12;
  localparam int unsigned OFF_RPT  = 16;
  localparam int unsigned OFF_GOOD = 20;
  localparam int unsigned OFF_FLAG = 24;
  localparam int unsigned OFF_RST  = 28;
  localparam int unsigned OFF_FPAS = 32;
  localparam int unsigned OFF_TAG  = 36;

  typedef enum logic [1:0] {OUT_PASS, OUT_FAIL, OUT_REPEAT} outcome_e;

  function automatic logic masked_equal(word_t act, word_t exp, word_t msk);
    return ((act ^ exp) & msk) == '0;
  endfunction

  function automatic outcome_e judge(logic eq, logic spent);
    if (eq) return OUT_PASS;
    if (spent) return OUT_FAIL;
    return OUT_REPEAT;
  endfunction

  function automatic logic [5:0] branch_slot(outcome_e o, logic term);
    case (o)
      OUT_REPEAT: return 6'(OFF_RPT);
      OUT_PASS:   return term ? 6'(OFF_FPAS) : 6'(OFF_GOOD);
      default:    return term ? 6'(OFF_RST) : 6'(OFF_GOOD);
    endcase
  endfunction
endpackage

// File: rtl/rcb_retry_ctr.sv
`timescale 1ns/1ps
module rcb_retry_ctr
  import rcb_pkg::*;
#(
  parameter int unsigned MAX_RETRY = 15
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd,
  input  outcome_e outcome_q,
  output logic     spent
);
  localparam int unsigned CW = $clog2(MAX_RETRY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (upd) begin
      if (outcome_q == OUT_REPEAT) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign spent = (cnt == CW'(MAX_RETRY));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_RETRY));
  // R6
  repeat_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && outcome_q == OUT_REPEAT) |=> cnt != '0);
  // R7
  decided_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && outcome_q != OUT_REPEAT) |=> cnt == '0);
endmodule

// File: rtl/rcb_verdict.sv
`timescale 1ns/1ps
module rcb_verdict
  import rcb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec_evt,
  input  word_t      act_q,
  input  word_t      msk_q,
  input  word_t      exp_q,
  input  logic       term_now,
  input  logic       spent,
  output logic [5:0] slot_off,
  output outcome_e   outcome_q
);
  logic     eq_now;
  outcome_e outcome_now;

  assign eq_now      = masked_equal(act_q, exp_q, msk_q);
  assign outcome_now = judge(eq_now, spent);
  assign slot_off    = branch_slot(outcome_now, term_now);

  always_ff @(posedge clk) begin
    if (!rst_n) outcome_q <= OUT_PASS;
    else if (dec_evt) outcome_q <= outcome_now;
  end

  // R7
  no_repeat_when_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && spent) |-> outcome_now != OUT_REPEAT);
  // R3
  match_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && act_q == exp_q) |=> outcome_q == OUT_PASS);
endmodule

// File: rtl/rcb_fetch_seq.sv
`timescale 1ns/1ps
module rcb_fetch_seq
  import rcb_pkg::*;
#(
  parameter int unsigned  AW       = 12,
  parameter logic [AW-1:0] SAVE_ACT = 12'h080,
  parameter logic [AW-1:0] SAVE_MSK = 12'h084
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] tbl_base,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output word_t         mem_wdata,
  input  word_t         mem_rdata,
  input  logic [5:0]    slot_off,
  input  outcome_e      outcome_q,
  output logic          dec_evt,
  output logic          done_evt,
  output word_t         act_q,
  output word_t         msk_q,
  output word_t         exp_q,
  output logic          res_valid,
  output logic          res_pass,
  output logic          res_repeat,
  output word_t         res_next,
  output logic [7:0]    res_test,
  output logic [7:0]    res_seg
);
  typedef enum logic [3:0] {
    S_IDLE, S_GET_W13, S_PUT_ACT, S_GET_W14, S_PUT_MSK,
    S_GET_PACT, S_GET_ACT, S_GET_PMSK, S_GET_MSK, S_GET_EXP,
    S_GET_FLG, S_DECIDE, S_GET_TAG, S_DONE
  } state_e;

  state_e        state_q, state_d;
  logic [AW-1:0] base_q;
  word_t         next_q;
  logic          accept;

  assign accept   = (state_q == S_IDLE) && start;
  assign dec_evt  = (state_q == S_DECIDE);
  assign done_evt = (state_q == S_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (start) state_d = S_GET_W13;
      S_DONE: state_d = S_IDLE;
      default: state_d = state_e'(state_q + 4'd1);
    endcase
  end

  always_comb begin
    mem_en    = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = mem_rdata;
    case (state_q)
      S_GET_W13:  mem_addr = base_q + AW'(OFF_PACT);
      S_PUT_ACT:  begin mem_we = 1'b1; mem_addr = SAVE_ACT; end
      S_GET_W14:  mem_addr = base_q + AW'(OFF_PMSK);
      S_PUT_MSK:  begin mem_we = 1'b1; mem_addr = SAVE_MSK; end
      S_GET_PACT: mem_addr = SAVE_ACT;
      S_GET_ACT:  mem_addr = mem_rdata[AW-1:0];
      S_GET_PMSK: mem_addr = SAVE_MSK;
      S_GET_MSK:  mem_addr = mem_rdata[AW-1:0];
      S_GET_EXP:  mem_addr = base_q + AW'(OFF_EXP);
      S_GET_FLG:  mem_addr = base_q + AW'(OFF_FLAG);
      S_DECIDE:   mem_addr = base_q + AW'(slot_off);
      S_GET_TAG:  mem_addr = base_q + AW'(OFF_TAG);
      default:    mem_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      base_q     <= '0;
      act_q      <= '0;
      msk_q      <= '0;
      exp_q      <= '0;
      next_q     <= '0;
      res_valid  <= 1'b0;
      res_pass   <= 1'b0;
      res_repeat <= 1'b0;
      res_next   <= '0;
      res_test   <= '0;
      res_seg    <= '0;
    end else begin
      state_q   <= state_d;
      res_valid <= done_evt;
      if (accept) base_q <= tbl_base;
      case (state_q)
        S_GET_PMSK: act_q  <= mem_rdata;
        S_GET_EXP:  msk_q  <= mem_rdata;
        S_GET_FLG:  exp_q  <= mem_rdata;
        S_GET_TAG:  next_q <= mem_rdata;
        S_DONE: begin
          res_pass   <= (outcome_q == OUT_PASS);
          res_repeat <= (outcome_q == OUT_REPEAT);
          res_next   <= next_q;
          res_test   <= mem_rdata[15:8];
          res_seg    <= mem_rdata[7:0];
        end
        default: ;
      endcase
    end
  end

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R1
  save_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr == SAVE_ACT || mem_addr == SAVE_MSK));
  // R10
  restart_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && state_q != S_DONE && start) |=> state_q != S_GET_W13);
  // R4
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_pass && res_repeat));
endmodule

// File: rtl/resp_check_branch.sv
`timescale 1ns/1ps
module resp_check_branch
  import rcb_pkg::*;
#(
  parameter int unsigned   AW        = 12,
  parameter int unsigned   MAX_RETRY = 15,
  parameter int unsigned   TERM_BIT  = 7,
  parameter logic [AW-1:0] SAVE_ACT  = 12'h080,
  parameter logic [AW-1:0] SAVE_MSK  = 12'h084
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] tbl_base,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          res_valid,
  output logic          res_pass,
  output logic          res_repeat,
  output logic [31:0]   res_next,
  output logic [7:0]    res_test,
  output logic [7:0]    res_seg
);
  logic       dec_evt, done_evt, spent, term_now;
  logic [5:0] slot_off;
  outcome_e   outcome_q;
  word_t      act_q, msk_q, exp_q;

  assign term_now = mem_rdata[TERM_BIT];

  rcb_fetch_seq #(.AW(AW), .SAVE_ACT(SAVE_ACT), .SAVE_MSK(SAVE_MSK)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .slot_off(slot_off), .outcome_q(outcome_q),
    .dec_evt(dec_evt), .done_evt(done_evt),
    .act_q(act_q), .msk_q(msk_q), .exp_q(exp_q),
    .res_valid(res_valid), .res_pass(res_pass), .res_repeat(res_repeat),
    .res_next(res_next), .res_test(res_test), .res_seg(res_seg)
  );

  rcb_verdict u_verdict (
    .clk(clk), .rst_n(rst_n), .dec_evt(dec_evt),
    .act_q(act_q), .msk_q(msk_q), .exp_q(exp_q),
    .term_now(term_now), .spent(spent),
    .slot_off(slot_off), .outcome_q(outcome_q)
  );

  rcb_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .upd(done_evt),
    .outcome_q(outcome_q), .spent(spent)
  );
endmodule

// File: tb/sim_resp_check_branch.sv
`timescale 1ns/1ps
module sim_resp_check_branch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] tbl_base = '0;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        res_valid, res_pass, res_repeat;
  logic [31:0] res_next;
  logic [7:0]  res_test, res_seg;

  logic [31:0] mem [0:1023];
  int vectors = 0;
  int fails = 0;
  int rc = 0;

  always #2 clk = ~clk;

  resp_check_branch u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_pass(res_pass), .res_repeat(res_repeat),
    .res_next(res_next), .res_test(res_test), .res_seg(res_seg)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[int'(mem_addr[11:2])] = mem_wdata;
      else mem_rdata <= mem[int'(mem_addr[11:2])];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit bits_agree(logic [31:0] a, logic [31:0] e, logic [31:0] m);
    for (int i = 0; i < 32; i++)
      if (m[i] == 1'b1 && a[i] != e[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic load(input int base, input int aptr, input logic [31:0] a,
                      input logic [31:0] m, input logic [31:0] e, input bit term,
                      input logic [31:0] tag);
    int wi = base / 4;
    mem[wi + 0] = 32'(aptr);
    mem[wi + 1] = 32'(base + 8);
    mem[wi + 2] = m;
    mem[wi + 3] = e;
    mem[wi + 4] = 32'h1700_0000 | 32'(base);
    mem[wi + 5] = 32'h1800_0000 | 32'(base);
    mem[wi + 6] = term ? 32'h0000_01C0 : 32'h0000_0140;
    mem[wi + 7] = 32'h2000_0000 | 32'(base);
    mem[wi + 8] = 32'h2100_0000 | 32'(base);
    mem[wi + 9] = tag;
    mem[aptr / 4] = a;
  endtask

  task automatic run(input int base, input bit poke);
    int wi = base / 4;
    logic [31:0] a, m, e, xnext, tag;
    bit term, xpass, xrep, eq;
    string rq;
    a = mem[int'(mem[wi][11:2])];
    m = mem[int'(mem[wi + 1][11:2])];
    e = mem[wi + 3];
    term = mem[wi + 6][7];
    tag = mem[wi + 9];
    eq = bits_agree(a, e, m);
    if (eq) begin
      xpass = 1; xrep = 0; xnext = term ? mem[wi + 8] : mem[wi + 5]; rc = 0; rq = "R4/R3";
    end else if (rc < 15) begin
      xpass = 0; xrep = 1; xnext = mem[wi + 4]; rc++; rq = "R6";
    end else begin
      xpass = 0; xrep = 0; xnext = term ? mem[wi + 7] : mem[wi + 5]; rc = 0; rq = "R7";
    end
    @(negedge clk); tbl_base = 12'(base); start = 1'b1;
    for (int lat = 1; lat <= 22; lat++) begin
      @(negedge clk);
      start = (poke && (lat == 5 || lat == 9)) ? 1'b1 : 1'b0;
      // R9 strobe timing, R10 no second strobe
      chk(res_valid == (lat == 14), poke ? "R10" : "R9", 32'(res_valid), 32'(lat == 14));
      if (mem_en && mem_we)
        chk(mem_addr == 12'h080 || mem_addr == 12'h084, "R1 write addr", 32'(mem_addr), 32'h80);
      if (res_valid) begin
        chk(res_pass == xpass, {rq, " pass"}, 32'(res_pass), 32'(xpass));
        chk(res_repeat == xrep, {rq, " repeat"}, 32'(res_repeat), 32'(xrep));
        chk(res_next == xnext, {rq, " R5 next"}, res_next, xnext);
        chk(res_test == tag[15:8], "R8 test", 32'(res_test), 32'(tag[15:8]));
        chk(res_seg == tag[7:0], "R8 seg", 32'(res_seg), 32'(tag[7:0]));
      end
    end
    start = 1'b0;
    chk(mem[32] == mem[wi], "R1 save act", mem[32], mem[wi]);
    chk(mem[33] == mem[wi + 1], "R2 save msk", mem[33], mem[wi + 1]);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(res_valid == 0, "R11 valid", 32'(res_valid), 0);
    chk(mem_en == 0, "R11 mem_en", 32'(mem_en), 0);
    chk(res_next == 0, "R11 next", res_next, 0);
    chk({res_test, res_seg} == 0, "R11 tag", 32'({res_test, res_seg}), 0);
    rst_n = 1'b1;

    // plain match, flag clear (neighbour bits 6 and 8 set)
    load(32'h100, 32'h600, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 0, 32'h0000_0312);
    run(32'h100, 0);
    // R3 difference only in masked-off bits, new base and pointer
    load(32'h300, 32'h700, 32'h1234_AB78, 32'hFFFF_00FF, 32'h1234_5678, 0, 32'h0000_0401);
    run(32'h300, 0);
    // R3 zero mask over unrelated words
    load(32'h100, 32'h640, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_FFFF, 0, 32'h0000_0502);
    run(32'h100, 0);
    // R5 flag set, match -> forced-pass address
    load(32'h300, 32'h680, 32'hCAFE_0001, 32'hF0F0_F0F1, 32'hCAFE_0001, 1, 32'h0000_0603);
    run(32'h300, 0);
    // R6 / R7 15 repeats then fail, flag clear
    load(32'h100, 32'h600, 32'h0000_0010, 32'h0000_00F0, 32'h0000_0000, 0, 32'h0000_0704);
    for (int k = 0; k < 16; k++) run(32'h100, 0);
    // R6 counter cleared after fail
    run(32'h100, 0);
    // R4 a pass after repeats clears the counter
    for (int k = 0; k < 13; k++) run(32'h100, 0);
    mem[32'h600 / 4] = 32'h0000_0000;
    run(32'h100, 0);
    // R7 fail with flag set after a fresh run of 15 repeats
    load(32'h300, 32'h700, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1, 32'h0000_0805);
    for (int k = 0; k < 16; k++) run(32'h300, 0);
    // R10 start pulses during a check are ignored
    load(32'h100, 32'h660, 32'h5555_5555, 32'hFFFF_FFFF, 32'h5555_5555, 0, 32'h0000_0906);
    run(32'h100, 1);
    load(32'h300, 32'h6C0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 0, 32'h0000_0A07);
    run(32'h300, 1);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule